// File: doc/BRIEF.md
# Ordered masked rule classifier

This block classifies packets by comparing a set of already-parsed header fields against a table of rules. The table is priority-ordered. Each rule holds a value, a bit mask for every field, an action code and a destination port. The result is the index, action and port of the lowest-numbered enabled rule that matches. It is returned as a registered result one cycle after the lookup is presented, and a new lookup can be accepted on every cycle.

The classified fields are:

- source and destination MAC address
- source and destination IPv4 address
- source and destination L4 port
- ethertype
- IP protocol number
- VLAN ID

The upstream parser takes them from the first 128 bytes of a frame.

Rules are loaded through a narrow register-style write port. The port fills a staging copy of one rule, word by word, and a commit command then copies the staged rule into a table slot in a single cycle. A separate command changes only a rule's enable bit. Because of this, the table can be edited while lookups keep flowing, and no lookup ever sees a half-written rule.

Top module: `rule_classifier`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high, and lookups on consecutive cycles each produce their own result on consecutive cycles.
- R2: The lookup key is {vid, proto, etype, dport, sport, dip, sip, dmac, smac}. Source MAC occupies bits 47:0, destination MAC 95:48, source IPv4 127:96, destination IPv4 159:128, source L4 port 175:160, destination L4 port 191:176, ethertype 207:192, IP protocol 215:208 and VLAN ID 227:216. A rule matches when, for every key bit whose mask bit is 1, the key bit equals the rule value bit; a mask bit of 0 is "don't care", so a rule whose mask is all zero matches every packet.
- R3: When several enabled rules match, the one with the lowest index is reported on `out_idx`.
- R4: On a hit, `out_hit` is 1, and `out_act` and `out_port` give the winning rule's action code and port. The action codes are 1 = drop, 2 = redirect and 3 = mirror.
- R5: When no enabled rule matches, `out_hit` is 0 and `out_act` is 0 ("no action"). In the same case `out_idx` and `out_port` are 0.
- R6: Write addresses 0 to 7 load staged value word w, which is key bits 32w+31:32w. Addresses 8 to 15 load the staged mask words in the same way. Address 16 loads the action (data bits 1:0) and the port (data bits 11:8). Address 17 commits the whole staged rule into the slot given by data bits 3:0 and sets that slot's enable bit to data bit 31. Staging writes alone do not change any lookup result.
- R7: Address 18 sets the enable bit of the rule in data bits 3:0 to data bit 31 and leaves the rule's contents unchanged. A disabled rule never matches, and re-enabling it restores its earlier behaviour.
- R8: A commit in the same cycle as a lookup does not affect that lookup, which sees the whole old rule. The next lookup sees the whole new rule.
- R9: After reset every rule is disabled, and `out_valid` and `out_hit` are 0.
- R10: While `in_valid` is low, `out_hit`, `out_idx`, `out_act` and `out_port` hold the result of the last lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Lookup strobe |
| in_smac | input | 48 | Source MAC address |
| in_dmac | input | 48 | Destination MAC address |
| in_sip | input | 32 | Source IPv4 address |
| in_dip | input | 32 | Destination IPv4 address |
| in_sport | input | 16 | Source L4 port |
| in_dport | input | 16 | Destination L4 port |
| in_etype | input | 16 | Ethertype |
| in_proto | input | 8 | IP protocol number |
| in_vid | input | 12 | VLAN ID |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration write address |
| cfg_wdata | input | 32 | Configuration write data |
| out_valid | output | 1 | Result valid |
| out_hit | output | 1 | A rule matched |
| out_idx | output | 4 | Index of the winning rule |
| out_act | output | 2 | Action code |
| out_port | output | 4 | Destination port |

## Verification
A rule commit and a lookup can fall in the same clock cycle. The bench provokes this by staging a catch-all rule for slot 0 and then raising the commit write and `in_valid` at the same edge. That lookup must still report the previous winner, slot 15, and the very next lookup of the same packet must report slot 0 with the new action and port. A partial or mixed rule would show up as a result matching neither the old rule nor the new one.

// File: rtl/rule_classifier.sv
module rule_classifier #(
  parameter int NRULES = 16,
  parameter int PORT_W = 4,
  parameter int IDX_W  = $clog2(NRULES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [47:0]       in_smac,
  input  logic [47:0]       in_dmac,
  input  logic [31:0]       in_sip,
  input  logic [31:0]       in_dip,
  input  logic [15:0]       in_sport,
  input  logic [15:0]       in_dport,
  input  logic [15:0]       in_etype,
  input  logic [7:0]        in_proto,
  input  logic [11:0]       in_vid,
  input  logic              cfg_we,
  input  logic [4:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic              out_valid,
  output logic              out_hit,
  output logic [IDX_W-1:0]  out_idx,
  output logic [1:0]        out_act,
  output logic [PORT_W-1:0] out_port
);
  localparam int KEY_W   = 228;
  localparam int WORDS   = (KEY_W + 31) / 32;
  localparam int ADDR_W  = 5;
  localparam logic [ADDR_W-1:0] A_ACT    = ADDR_W'(2 * WORDS);
  localparam logic [ADDR_W-1:0] A_COMMIT = ADDR_W'(2 * WORDS + 1);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(2 * WORDS + 2);

  logic [KEY_W-1:0] key;
  assign key = {in_vid, in_proto, in_etype, in_dport, in_sport, in_dip, in_sip, in_dmac, in_smac};

  logic [KEY_W-1:0]  stg_val, stg_msk;
  logic [1:0]        stg_act;
  logic [PORT_W-1:0] stg_port;

  logic [KEY_W-1:0]  r_val  [NRULES];
  logic [KEY_W-1:0]  r_msk  [NRULES];
  logic [1:0]        r_act  [NRULES];
  logic [PORT_W-1:0] r_port [NRULES];
  logic [NRULES-1:0] r_en;

  wire [IDX_W-1:0] wr_idx = cfg_wdata[IDX_W-1:0];
  wire             do_commit = cfg_we && cfg_addr == A_COMMIT;

  always_ff @(posedge clk) begin
    if (cfg_we) begin
      for (int b = 0; b < KEY_W; b++) begin
        if (cfg_addr == ADDR_W'(b / 32))         stg_val[b] <= cfg_wdata[b % 32];
        if (cfg_addr == ADDR_W'(WORDS + b / 32)) stg_msk[b] <= cfg_wdata[b % 32];
      end
      if (cfg_addr == A_ACT) begin
        stg_act  <= cfg_wdata[1:0];
        stg_port <= cfg_wdata[8 +: PORT_W];
      end
    end
    if (do_commit) begin
      r_val[wr_idx]  <= stg_val & stg_msk;
      r_msk[wr_idx]  <= stg_msk;
      r_act[wr_idx]  <= stg_act;
      r_port[wr_idx] <= stg_port;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      r_en <= '0;
    else if (cfg_we && (cfg_addr == A_COMMIT || cfg_addr == A_ENABLE))
      r_en[wr_idx] <= cfg_wdata[31];
  end

  logic [NRULES-1:0] hit_vec;
  for (genvar i = 0; i < NRULES; i++) begin : g_cmp
    assign hit_vec[i] = r_en[i] && (((key & r_msk[i]) ^ r_val[i]) == '0);
  end

  logic             sel_hit;
  logic [IDX_W-1:0] sel_idx;
  always_comb begin
    sel_hit = 1'b0;
    sel_idx = '0;
    for (int i = NRULES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        sel_hit = 1'b1;
        sel_idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_idx   <= '0;
      out_act   <= '0;
      out_port  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_hit  <= sel_hit;
        out_idx  <= sel_idx;
        out_act  <= sel_hit ? r_act[sel_idx]  : 2'd0;
        out_port <= sel_hit ? r_port[sel_idx] : '0;
      end
    end
  end
endmodule

// File: rtl/rule_classifier_chk.sv
module rule_classifier_chk #(
  parameter int PORT_W = 4,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              out_valid,
  input logic              out_hit,
  input logic [IDX_W-1:0]  out_idx,
  input logic [1:0]        out_act,
  input logic [PORT_W-1:0] out_port
);
  a_r1_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r5_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (out_act == 2'd0 && out_idx == '0 && out_port == '0));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_hit) && $stable(out_idx) && $stable(out_act) && $stable(out_port)));

  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && !out_hit));
endmodule

bind rule_classifier rule_classifier_chk #(.PORT_W(PORT_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_hit(out_hit), .out_idx(out_idx), .out_act(out_act), .out_port(out_port));

// File: tb/sim_rule_classifier.sv
module sim_rule_classifier;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [47:0] in_smac = '0, in_dmac = '0;
  logic [31:0] in_sip = '0, in_dip = '0;
  logic [15:0] in_sport = '0, in_dport = '0, in_etype = '0;
  logic [7:0]  in_proto = '0;
  logic [11:0] in_vid = '0;
  logic cfg_we = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic out_valid, out_hit;
  logic [3:0] out_idx, out_port;
  logic [1:0] out_act;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rule_classifier u0 (.*);

  typedef struct packed {
    logic [31:0] dip; logic [15:0] dport; logic [7:0] proto; logic [11:0] vid;
    logic hit; logic [3:0] idx; logic [1:0] act; logic [3:0] port;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{32'h0A000005, 16'd80, 8'd6,  12'h001, 1'b1, 4'd2, 2'd2, 4'd3},
    '{32'h0A000006, 16'd80, 8'd6,  12'h001, 1'b1, 4'd7, 2'd1, 4'd0},
    '{32'hC0A80101, 16'd53, 8'd17, 12'h001, 1'b1, 4'd5, 2'd3, 4'd7},
    '{32'h0A000005, 16'd53, 8'd17, 12'h001, 1'b1, 4'd2, 2'd2, 4'd3},
    '{32'hC0A80101, 16'd80, 8'd6,  12'h06A, 1'b1, 4'd9, 2'd3, 4'd9},
    '{32'hC0A80101, 16'd80, 8'd6,  12'h07A, 1'b0, 4'd0, 2'd0, 4'd0},
    '{32'hC0A80101, 16'd53, 8'd6,  12'h001, 1'b0, 4'd0, 2'd0, 4'd0},
    '{32'h0B000005, 16'd80, 8'd6,  12'h065, 1'b1, 4'd9, 2'd3, 4'd9}
  };

  function automatic logic [227:0] mk_key(logic [31:0] dip, logic [15:0] dport,
                                          logic [7:0] proto, logic [11:0] vid);
    return {vid, proto, 16'h0800, dport, 16'd1234, dip, 32'hC0A80064,
            48'h00005E000001, 48'h02AABBCCDDEE};
  endfunction

  function automatic logic [227:0] mk_mask(logic [31:0] dip, logic [15:0] dport,
                                           logic [7:0] proto, logic [11:0] vid);
    return {vid, proto, 16'h0, dport, 16'h0, dip, 32'h0, 48'h0, 48'h0};
  endfunction

  task automatic set_pkt(logic [227:0] k);
    {in_vid, in_proto, in_etype, in_dport, in_sport, in_dip, in_sip, in_dmac, in_smac} = k;
  endtask

  task automatic cfg_write(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic stage_rule(logic [227:0] v, logic [227:0] m, logic [1:0] act, logic [3:0] port);
    for (int w = 0; w < 8; w++) cfg_write(5'(w), 32'(v >> (32 * w)));
    for (int w = 0; w < 8; w++) cfg_write(5'(8 + w), 32'(m >> (32 * w)));
    cfg_write(5'd16, (32'(port) << 8) | 32'(act));
  endtask

  task automatic load_rule(int idx, logic [227:0] v, logic [227:0] m, logic [1:0] act, logic [3:0] port);
    stage_rule(v, m, act, port);
    cfg_write(5'd17, 32'h80000000 | 32'(idx));
  endtask

  task automatic check(string req, logic [11:0] got, logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [11:0] res();
    return {out_valid, out_hit, out_idx, out_act, out_port};
  endfunction

  function automatic logic [11:0] mk_res(logic v, logic h, logic [3:0] i, logic [1:0] a, logic [3:0] p);
    return {v, h, i, a, p};
  endfunction

  task automatic lookup(logic [227:0] k);
    @(negedge clk);
    set_pkt(k); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset", res(), 12'h000);
    rst_n = 1'b1;
    lookup(mk_key(32'h0A000005, 16'd80, 8'd6, 12'h001));
    check("R9 empty table miss", res(), mk_res(1, 0, 0, 0, 0));

    load_rule(2, mk_key(32'h0A000005, 16'd0, 8'd0, 12'h0), mk_mask(32'hFFFFFFFF, 16'h0, 8'h0, 12'h0), 2'd2, 4'd3);
    load_rule(5, mk_key(32'h0, 16'd53, 8'd17, 12'h0), mk_mask(32'h0, 16'hFFFF, 8'hFF, 12'h0), 2'd3, 4'd7);
    load_rule(7, mk_key(32'h0A000000, 16'd0, 8'd0, 12'h0), mk_mask(32'hFF000000, 16'h0, 8'h0, 12'h0), 2'd1, 4'd0);
    load_rule(9, mk_key(32'h0, 16'd0, 8'd0, 12'h064), mk_mask(32'h0, 16'h0, 8'h0, 12'hFF0), 2'd3, 4'd9);

    for (int n = 0; n < NV; n++) begin
      lookup(mk_key(VEC[n].dip, VEC[n].dport, VEC[n].proto, VEC[n].vid));
      check("R2 R3 R4 R5 table", res(), mk_res(1, VEC[n].hit, VEC[n].idx, VEC[n].act, VEC[n].port));
    end

    @(negedge clk);
    check("R10 hold", res(), mk_res(0, 1, 9, 3, 9));

    @(negedge clk);
    set_pkt(mk_key(VEC[0].dip, VEC[0].dport, VEC[0].proto, VEC[0].vid)); in_valid = 1'b1;
    @(negedge clk);
    set_pkt(mk_key(VEC[2].dip, VEC[2].dport, VEC[2].proto, VEC[2].vid));
    check("R1 back-to-back first", res(), mk_res(1, 1, 2, 2, 3));
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 back-to-back second", res(), mk_res(1, 1, 5, 3, 7));

    cfg_write(5'd0, 32'hFFFFFFFF);
    cfg_write(5'd12, 32'h00000000);
    cfg_write(5'd16, 32'h00000F01);
    lookup(mk_key(VEC[0].dip, VEC[0].dport, VEC[0].proto, VEC[0].vid));
    check("R6 staging without commit", res(), mk_res(1, 1, 2, 2, 3));

    cfg_write(5'd18, 32'h00000002);
    lookup(mk_key(VEC[0].dip, VEC[0].dport, VEC[0].proto, VEC[0].vid));
    check("R7 disabled rule skipped", res(), mk_res(1, 1, 7, 1, 0));
    cfg_write(5'd18, 32'h80000002);
    lookup(mk_key(VEC[0].dip, VEC[0].dport, VEC[0].proto, VEC[0].vid));
    check("R7 re-enabled", res(), mk_res(1, 1, 2, 2, 3));

    load_rule(15, '0, '0, 2'd1, 4'd5);
    lookup(mk_key(VEC[5].dip, VEC[5].dport, VEC[5].proto, VEC[5].vid));
    check("R2 all-zero mask matches", res(), mk_res(1, 1, 15, 1, 5));

    stage_rule('0, '0, 2'd2, 4'd1);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'd17; cfg_wdata = 32'h80000000;
    set_pkt(mk_key(VEC[5].dip, VEC[5].dport, VEC[5].proto, VEC[5].vid)); in_valid = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    check("R8 collision sees old rule", res(), mk_res(1, 1, 15, 1, 5));
    lookup(mk_key(VEC[5].dip, VEC[5].dport, VEC[5].proto, VEC[5].vid));
    check("R8 next lookup sees new rule", res(), mk_res(1, 1, 0, 2, 1));

    finish_run();
  end
endmodule